// File: doc/BRIEF.md
# Configurable 32-bit Shift Unit

This block is the shift stage of an arithmetic accelerator. It keeps a 32-bit operand register and a one-bit carry register, and it moves the operand by a programmed number of bit positions. Each clock performs one single-bit step. A control byte selects the direction and sets the step count. Two further control bits choose what enters the vacated end of the word and whether the carry takes part. The possible paths are a plain shift with zero fill, a 32-bit rotate, a shift that fills from the carry, and a 33-bit rotate in which the carry sits inside the ring.

Software writes the operand, the carry and the control byte while the unit is idle, then pulses start. While `busy` is high, every write and any further start pulse are ignored. A one-cycle `done` pulse marks the completion. The result and the carry then stay in place until they are written again or the next shift runs. A separate reinitialise input clears only the direction bit of the control byte.

Top module: `acc_shift_unit`

## Requirements
- R1: After reset the control byte, operand, carry, `busy` and `done` all read 0.
- R2: Control byte fields: bit 7 is direction (0 = toward the MSB, 1 = toward the LSB), bit 6 is circular enable, bit 5 is carry enable, and bits 4..0 are the step count. A write made while idle reads back unchanged on `ctl_rdata`.
- R3: In direction 0 each step moves bit i to bit i+1. In direction 1 each step moves bit i+1 to bit i.
- R4: With carry enable 0 and circular enable 0, the vacated end takes 0 and the carry is unchanged.
- R5: With carry enable 0 and circular enable 1, the word rotates on 32 bits (the bit leaving one end enters the other end) and the carry is unchanged.
- R6: With carry enable 1 and circular enable 0, the vacated end takes the carry value on every step and the carry is unchanged.
- R7: With both enables set, the word and the carry rotate as one 33-bit ring. In direction 0 the carry enters bit 0 and bit 31 enters the carry. In direction 1 the carry enters bit 31 and bit 0 enters the carry.
- R8: A start with a count N>0 raises `busy` on the next cycle and keeps it high for exactly N cycles. `done` is high for one cycle, in the first cycle after `busy` falls. The result equals N single-bit steps.
- R9: A start with count 0 gives a `done` pulse on the next cycle. `busy` does not rise, and the operand and carry do not change.
- R10: While `busy` is high, writes to the operand, the carry and the control byte, and any start pulse, have no effect.
- R11: A reinitialise pulse clears the direction bit and leaves the other control bits as they were.
- R12: While idle and with no write or start, the operand and carry hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reinit | input | 1 | Accelerator reinitialise, clears the direction bit |
| ctl_we | input | 1 | Control byte write enable |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data |
| opd_we | input | 1 | Operand write enable |
| opd_wdata | input | 32 | Operand write data |
| opd_q | output | 32 | Operand / result |
| cy_we | input | 1 | Carry write enable |
| cy_wdata | input | 1 | Carry write data |
| cy_q | output | 1 | Carry bit |
| start | input | 1 | Start pulse |
| busy | output | 1 | Shift in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The step properties assume that the mode seen by the datapath is the one captured at start, so changes to the control byte in mid-run cannot touch them. The lock properties exclude reinitialise, which is allowed to clear the direction bit at any time. The stimulus writes the operand, carry and control byte together in one idle cycle and raises start only in a later cycle, so start never coincides with a write. Locked writes, a start while busy and a reinitialise pulse are each driven on purpose in their own directed tests.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef struct packed {
      logic dir;   // 0: toward MSB, 1: toward LSB
      logic circ;  // wrap the leaving bit
      logic cyen;  // carry takes part in the path
   } shf_mode_t;

   localparam int MODE_BITS = 3;
endpackage

// File: rtl/shf_ctl_reg.sv
module shf_ctl_reg
   import shf_pkg::*;
#(
   parameter int CNT_W = 5,
   localparam int CTL_W = CNT_W + MODE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reinit,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wdata,
   output shf_mode_t        mode,
   output logic [CNT_W-1:0] count,
   output logic [CTL_W-1:0] rdata
);
   logic [CTL_W-1:0] ctl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (wr_en)  ctl_q <= wdata;
         if (reinit) ctl_q[CTL_W-1] <= 1'b0;
      end
   end

   assign mode.dir  = ctl_q[CTL_W-1];
   assign mode.circ = ctl_q[CTL_W-2];
   assign mode.cyen = ctl_q[CTL_W-3];
   assign count     = ctl_q[CNT_W-1:0];
   assign rdata     = ctl_q;
endmodule

// File: rtl/shf_step.sv
module shf_step
   import shf_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  shf_mode_t         mode,
   input  logic [DATA_W-1:0] d,
   input  logic              cy,
   output logic [DATA_W-1:0] nd,
   output logic              ncy
);
   logic out_bit;
   logic fill;

   assign out_bit = mode.dir ? d[0] : d[DATA_W-1];
   assign fill    = mode.cyen ? cy : (mode.circ ? out_bit : 1'b0);
   assign ncy     = (mode.cyen && mode.circ) ? out_bit : cy;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign nd[i] = mode.dir ? d[i+1] : fill;
      end else if (i == DATA_W-1) begin : g_msb
         assign nd[i] = mode.dir ? fill : d[i-1];
      end else begin : g_mid
         assign nd[i] = mode.dir ? d[i+1] : d[i-1];
      end
   end
endmodule

// File: rtl/shf_seq.sv
module shf_seq #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic [CNT_W-1:0] count,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         rem_q <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            rem_q <= rem_q - 1'b1;
            if (rem_q == CNT_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end else if (launch) begin
            if (count == '0) begin
               done <= 1'b1;
            end else begin
               busy  <= 1'b1;
               rem_q <= count;
            end
         end
      end
   end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5,
   localparam int CTL_W = CNT_W + MODE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reinit,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              opd_we,
   input  logic [DATA_W-1:0] opd_wdata,
   output logic [DATA_W-1:0] opd_q,
   input  logic              cy_we,
   input  logic              cy_wdata,
   output logic              cy_q,
   input  logic              start,
   output logic              busy,
   output logic              done
);
   if (DATA_W < 2) begin : g_bad_data_w
      $error("acc_shift_unit: DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("acc_shift_unit: CNT_W must be at least 1");
   end

   shf_mode_t         ctl_mode;
   shf_mode_t         mode_q;
   logic [CNT_W-1:0]  ctl_count;
   logic [DATA_W-1:0] step_d;
   logic              step_cy;
   logic              idle;

   assign idle = !busy;

   shf_ctl_reg #(.CNT_W(CNT_W)) u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .reinit(reinit),
      .wr_en (ctl_we && idle),
      .wdata (ctl_wdata),
      .mode  (ctl_mode),
      .count (ctl_count),
      .rdata (ctl_rdata)
   );

   shf_seq #(.CNT_W(CNT_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .launch(start && idle),
      .count (ctl_count),
      .busy  (busy),
      .done  (done)
   );

   shf_step #(.DATA_W(DATA_W)) u_step (
      .mode(mode_q),
      .d   (opd_q),
      .cy  (cy_q),
      .nd  (step_d),
      .ncy (step_cy)
   );

   // Mode is captured at launch so a reinitialise cannot bend a running shift.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (start && idle) begin
         mode_q <= ctl_mode;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opd_q <= '0;
         cy_q  <= 1'b0;
      end else if (busy) begin
         opd_q <= step_d;
         cy_q  <= step_cy;
      end else begin
         if (opd_we) opd_q <= opd_wdata;
         if (cy_we)  cy_q  <= cy_wdata;
      end
   end
endmodule

// File: rtl/shf_chk.sv
module shf_chk
   import shf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5,
   localparam int CTL_W = CNT_W + MODE_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reinit,
   input logic              start,
   input logic              opd_we,
   input logic              cy_we,
   input logic              busy,
   input logic              done,
   input logic [CTL_W-1:0]  ctl_rdata,
   input logic [DATA_W-1:0] opd_q,
   input logic              cy_q,
   input shf_mode_t         mode
);
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   p_ctl_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !reinit |=> $stable(ctl_rdata));

   p_carry_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(mode.cyen && mode.circ) |=> $stable(cy_q));

   p_left_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mode.dir |=> opd_q[DATA_W-1:1] == $past(opd_q[DATA_W-2:0]));

   p_right_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mode.dir |=> opd_q[DATA_W-2:0] == $past(opd_q[DATA_W-1:1]));

   p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !mode.dir && !mode.circ && !mode.cyen |=> !opd_q[0]);

   p_reinit_dir_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> !ctl_rdata[CTL_W-1]);

   p_opd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start && !opd_we |=> $stable(opd_q));

   p_cy_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start && !cy_we |=> $stable(cy_q));
endmodule

bind acc_shift_unit shf_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reinit   (reinit),
   .start    (start),
   .opd_we   (opd_we),
   .cy_we    (cy_we),
   .busy     (busy),
   .done     (done),
   .ctl_rdata(ctl_rdata),
   .opd_q    (opd_q),
   .cy_q     (cy_q),
   .mode     (mode_q)
);

// File: tb/sim_acc_shift_unit.sv
`timescale 1ns/1ps
module sim_acc_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reinit = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic [7:0]  ctl_rdata;
   logic        opd_we = 1'b0;
   logic [31:0] opd_wdata = '0;
   logic [31:0] opd_q;
   logic        cy_we = 1'b0;
   logic        cy_wdata = 1'b0;
   logic        cy_q;
   logic        start = 1'b0;
   logic        busy;
   logic        done;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   acc_shift_unit u0 (
      .clk(clk), .rst_n(rst_n), .reinit(reinit),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .opd_we(opd_we), .opd_wdata(opd_wdata), .opd_q(opd_q),
      .cy_we(cy_we), .cy_wdata(cy_wdata), .cy_q(cy_q),
      .start(start), .busy(busy), .done(done)
   );

   // {control byte, carry in, operand in}
   localparam logic [40:0] VEC [16] = '{
      {8'h03, 1'b0, 32'hA5A5_0F0F},
      {8'h83, 1'b0, 32'hF000_000F},
      {8'h44, 1'b0, 32'h8000_0001},
      {8'hC4, 1'b0, 32'h8000_0001},
      {8'h25, 1'b1, 32'h1234_5678},
      {8'hA5, 1'b1, 32'h1234_5678},
      {8'h21, 1'b0, 32'hFFFF_FFFF},
      {8'h65, 1'b1, 32'h8000_0000},
      {8'hE5, 1'b1, 32'h0000_0001},
      {8'h7F, 1'b0, 32'hDEAD_BEEF},
      {8'hFF, 1'b1, 32'hDEAD_BEEF},
      {8'h1F, 1'b0, 32'hFFFF_FFFF},
      {8'h9F, 1'b0, 32'hFFFF_FFFF},
      {8'h01, 1'b0, 32'h8000_0000},
      {8'h60, 1'b1, 32'hCAFE_F00D},
      {8'hC1, 1'b1, 32'h0000_0001}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [7:0] c);
      case (c[6:5])
         2'b00:   return "R4";
         2'b10:   return "R5";
         2'b01:   return "R6";
         default: return "R7";
      endcase
   endfunction

   // Whole-shift result from the requirements: {carry, operand}
   function automatic logic [32:0] ref_shift(input logic [7:0] c,
                                             input logic cin, input logic [31:0] d);
      int n = int'(c[4:0]);
      logic [32:0] v = {cin, d};
      logic [32:0] r;
      logic [31:0] o;
      case ({c[7], c[6], c[5]})
         3'b000: o = d << n;
         3'b100: o = d >> n;
         3'b010: o = (d << n) | (d >> (32 - n));
         3'b110: o = (d >> n) | (d << (32 - n));
         3'b001: o = (d << n) | (cin ? ((32'h1 << n) - 32'h1) : 32'h0);
         3'b101: o = (d >> n) | (cin ? ~(32'hFFFF_FFFF >> n) : 32'h0);
         default: o = d;
      endcase
      if (c[6] && c[5]) begin
         if (n == 0)     r = v;
         else if (!c[7]) r = (v << n) | (v >> (33 - n));
         else            r = (v >> n) | (v << (33 - n));
         return r;
      end
      return {cin, o};
   endfunction

   task automatic run_vec(input logic [7:0] c, input logic cin, input logic [31:0] d);
      logic [32:0] e;
      int cnt;
      e = ref_shift(c, cin, d);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = c;
      opd_we = 1'b1; opd_wdata = d;
      cy_we  = 1'b1; cy_wdata  = cin;
      @(negedge clk);
      ctl_we = 1'b0; opd_we = 1'b0; cy_we = 1'b0;
      chk({24'h0, ctl_rdata}, {24'h0, c}, "R2", "control readback");
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      while (busy) begin
         cnt++;
         if (done) chk(32'h1, 32'h0, "R8", "done while busy");
         @(negedge clk);
      end
      chk({31'h0, done}, 32'h1, "R8", "done after last step");
      chk(cnt, {27'h0, c[4:0]}, "R8", "busy cycles");
      chk(opd_q, e[31:0], mode_tag(c), c[7] ? "R3 result dir 1" : "R3 result dir 0");
      chk({31'h0, cy_q}, {31'h0, e[32]}, mode_tag(c), "carry");
      @(negedge clk);
      chk({31'h0, done}, 32'h0, "R8", "done one cycle wide");
   endtask

   initial begin : main
      int cnt;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk({24'h0, ctl_rdata}, 32'h0, "R1", "control after reset");
      chk(opd_q, 32'h0, "R1", "operand after reset");
      chk({31'h0, cy_q}, 32'h0, "R1", "carry after reset");
      chk({30'h0, busy, done}, 32'h0, "R1", "busy/done after reset");
      rst_n = 1'b1;

      for (int i = 0; i < 16; i++) run_vec(VEC[i][40:33], VEC[i][32], VEC[i][31:0]);

      // R9: zero count
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 8'hE0;
      opd_we = 1'b1; opd_wdata = 32'hCAFE_F00D; cy_we = 1'b1; cy_wdata = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; opd_we = 1'b0; cy_we = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({30'h0, busy, done}, 32'h1, "R9", "zero count busy/done");
      chk(opd_q, 32'hCAFE_F00D, "R9", "zero count operand");
      chk({31'h0, cy_q}, 32'h1, "R9", "zero count carry");

      // R10: writes and start while busy are dropped
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 8'h0A;
      opd_we = 1'b1; opd_wdata = 32'h0000_0001; cy_we = 1'b1; cy_wdata = 1'b0;
      @(negedge clk);
      ctl_we = 1'b0; opd_we = 1'b0; cy_we = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ctl_we = 1'b1; ctl_wdata = 8'hFF;
      opd_we = 1'b1; opd_wdata = 32'hFFFF_FFFF; cy_we = 1'b1; cy_wdata = 1'b1;
      start = 1'b1;
      cnt = 0;
      while (busy) begin
         cnt++;
         @(negedge clk);
         ctl_we = 1'b0; opd_we = 1'b0; cy_we = 1'b0; start = 1'b0;
      end
      chk(cnt, 32'd10, "R10", "busy cycles with locked writes");
      chk(opd_q, 32'h0000_0400, "R10", "operand after locked write");
      chk({31'h0, cy_q}, 32'h0, "R10", "carry after locked write");
      chk({24'h0, ctl_rdata}, 32'h0A, "R10", "control after locked write");
      @(negedge clk);
      chk({31'h0, busy}, 32'h0, "R10", "start while busy ignored");

      // R12: idle hold
      repeat (5) @(negedge clk);
      chk(opd_q, 32'h0000_0400, "R12", "operand holds");
      chk({31'h0, cy_q}, 32'h0, "R12", "carry holds");

      // R11: reinitialise clears direction only
      ctl_we = 1'b1; ctl_wdata = 8'hFF;
      @(negedge clk);
      ctl_we = 1'b0; reinit = 1'b1;
      @(negedge clk);
      reinit = 1'b0;
      chk({24'h0, ctl_rdata}, 32'h7F, "R11", "control after reinit");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule